// File: doc/BRIEF.md
# Interval Timer Register Front End

This block is the byte-wide register interface that sits in front of up to three independent down-counter channels. A host reaches it through a 2-bit address and single-cycle read and write strobes. Addresses 0 to 2 carry count data for the matching channel, and address 3 takes control words. The block decodes each control word into a channel's access order, operating mode and BCD flag. It assembles the bytes written by the host into 16-bit reload values. It also turns a live count or a status snapshot into a sequence of bytes for the host to read.

Each channel has a live-count input and an OUT input from its counter, and a "count transferred" pulse back from the counter. The block drives the channel's mode, BCD flag, reload value and a one-cycle load strobe. The counting datapath is not part of this block. Snapshots can be taken for one channel with a latch control word, or for several channels at once with a read-back command. A snapshot is taken once and is held until the host has read it out.

Top module: `tmr_ctrl_if`

## Requirements
- R1: After reset every channel has mode 0, BCD 0, two-byte access and null count clear. `rdata`, every reload value and every load strobe are zero.
- R2: A write to address 3 with bits 7:6 below 3 configures the channel named by bits 7:6, provided bits 5:4 are nonzero. Bits 5:4 give the access order (1 = low byte only, 2 = high byte only, 3 = low then high), bits 3:1 give the mode and bit 0 gives BCD. Mode codes 6 and 7 are stored as 2 and 3.
- R3: In low-byte-only access, a data write loads the reload value {8'h00, byte}. `chan_load` of that channel pulses for exactly one cycle, in the cycle after the write, with the new reload value.
- R4: In high-byte-only access, a data write loads {byte, 8'h00}.
- R5: In two-byte access, the first data write loads nothing and only holds its byte. The second write loads {second, first}, and the next write is again treated as a first byte.
- R6: A configuring control word sets the channel's read and write byte pointers back to the low byte.
- R7: A control word with bits 5:4 equal to 0 captures that channel's live count. The following reads return the captured bytes in the channel's access order (low only, high only, or low then high), and after that the snapshot is released.
- R8: A count capture or status capture request is ignored while an earlier capture of the same kind on that channel is still unread.
- R9: A read-back command (bits 7:6 = 3) acts on every channel whose select bit is set (bit 1 = channel 0, bit 2 = channel 1, bit 3 = channel 2). It captures the count when bit 5 is 0 and the status when bit 4 is 0.
- R10: The status byte is {OUT, null count, access[1:0], mode[2:0], BCD}, from bit 7 down to bit 0. A pending status is read before a pending count.
- R11: Null count is set by each reload that is loaded, and is cleared by the channel's `chan_loaded` pulse.
- R12: With nothing captured, reads return live count bytes, stepping low then high in two-byte access. Read data appears on `rdata` one cycle after `rd_en`, and a read of address 3 returns 8'h00.
- R13: `rdata` keeps its value in every cycle after which `rd_en` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Single-cycle write strobe |
| rd_en | input | 1 | Single-cycle read strobe |
| addr | input | 2 | 0..2 channel data, 3 control |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Registered read byte |
| live_count | input | 3*16 | Live count of each channel, channel 0 in the low bits |
| chan_out | input | 3 | OUT level of each channel |
| chan_loaded | input | 3 | Pulse: counter has taken its reload value |
| chan_mode | output | 3*3 | Mode of each channel |
| chan_bcd | output | 3 | BCD flag of each channel |
| chan_reload | output | 3*16 | Reload value of each channel |
| chan_load | output | 3 | One-cycle load strobe of each channel |

## Verification
A byte pointer that is out of step shows up at once. The next two-byte load comes out with its bytes swapped, or it is missing its strobe, and the next live read returns the wrong half. A capture flag that is stuck or released early shows up on the first read after it. That read returns a live byte where a snapshot byte was due, or returns a stale snapshot a second time. The tests therefore change the live counts between capture and read. They also keep interleaving loads, captures and reads on the same channel, so that any such error appears within one or two host accesses.

// File: rtl/tmr_ctrl_pkg.sv
package tmr_ctrl_pkg;

   typedef enum logic [1:0] {
      ACC_CAPTURE = 2'd0,
      ACC_LO      = 2'd1,
      ACC_HI      = 2'd2,
      ACC_WORD    = 2'd3
   } acc_e;

   typedef struct packed {
      logic [1:0] sel;
      logic [1:0] acc;
      logic [2:0] mode;
      logic       bcd;
   } ctrl_word_t;

   localparam logic [1:0] SEL_READBACK = 2'd3;
   localparam logic [1:0] ADDR_CTRL    = 2'd3;

endpackage

// File: rtl/tmr_cmd_decode.sv
module tmr_cmd_decode
   import tmr_ctrl_pkg::*;
#(
   parameter int NUM_CH     = 3,
   parameter int DATA_W     = 8,
   parameter bit MODE_ALIAS = 1'b1
) (
   input  logic              wr_en,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [NUM_CH-1:0] cfg_wr,
   output logic [NUM_CH-1:0] data_wr,
   output logic [NUM_CH-1:0] cnt_grab,
   output logic [NUM_CH-1:0] st_grab,
   output logic [1:0]        new_acc,
   output logic [2:0]        new_mode,
   output logic              new_bcd
);

   ctrl_word_t cw;
   logic       is_ctrl;
   logic       is_rb;

   assign cw      = ctrl_word_t'(wdata[7:0]);
   assign is_ctrl = wr_en && (addr == ADDR_CTRL);
   assign is_rb   = is_ctrl && (cw.sel == SEL_READBACK);
   assign new_acc = cw.acc;
   assign new_bcd = cw.bcd;

   generate
      if (MODE_ALIAS) begin : g_fold
         assign new_mode = (cw.mode[2] && cw.mode[1]) ? {1'b0, cw.mode[1:0]} : cw.mode;
      end else begin : g_raw
         assign new_mode = cw.mode;
      end
   endgenerate

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         logic named;
         assign named      = is_ctrl && (cw.sel == 2'(i));
         assign data_wr[i] = wr_en && (addr == 2'(i));
         assign cfg_wr[i]  = named && (cw.acc != ACC_CAPTURE);
         assign cnt_grab[i] = (named && (cw.acc == ACC_CAPTURE))
                            || (is_rb && wdata[i+1] && !wdata[5]);
         assign st_grab[i]  = is_rb && wdata[i+1] && !wdata[4];
      end
   endgenerate

endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
   import tmr_ctrl_pkg::*;
#(
   parameter int DATA_W = 8,
   localparam int CNT_W = 2 * DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_wr,
   input  logic [1:0]        new_acc,
   input  logic [2:0]        new_mode,
   input  logic              new_bcd,
   input  logic              data_wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              cnt_grab,
   input  logic              st_grab,
   input  logic              rd_hit,
   input  logic [CNT_W-1:0]  live,
   input  logic              out_lvl,
   input  logic              loaded,
   output logic [2:0]        mode,
   output logic              bcd,
   output logic [CNT_W-1:0]  reload,
   output logic              load,
   output logic [DATA_W-1:0] rbyte
);

   logic [1:0]        acc;
   logic              wr_hi;
   logic              rd_hi;
   logic [DATA_W-1:0] hold;
   logic [1:0]        snap_state;
   logic [CNT_W-1:0]  snap_val;
   logic              st_pend;
   logic [7:0]        st_val;
   logic              null_cnt;
   logic              load_now;
   logic [CNT_W-1:0]  load_val;

   always_comb begin
      if (st_pend)
         rbyte = DATA_W'(st_val);
      else if (snap_state != 2'd0)
         rbyte = (snap_state == ACC_HI) ? snap_val[CNT_W-1:DATA_W] : snap_val[DATA_W-1:0];
      else if ((acc == ACC_HI) || ((acc == ACC_WORD) && rd_hi))
         rbyte = live[CNT_W-1:DATA_W];
      else
         rbyte = live[DATA_W-1:0];
   end

   always_comb begin
      load_now = 1'b0;
      load_val = '0;
      if (data_wr) begin
         unique case (acc)
            ACC_HI:   begin load_now = 1'b1; load_val = {wdata, {DATA_W{1'b0}}}; end
            ACC_WORD: begin load_now = wr_hi; load_val = {wdata, hold}; end
            default:  begin load_now = 1'b1; load_val = {{DATA_W{1'b0}}, wdata}; end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc        <= ACC_WORD;
         mode       <= '0;
         bcd        <= 1'b0;
         wr_hi      <= 1'b0;
         rd_hi      <= 1'b0;
         hold       <= '0;
         snap_state <= '0;
         snap_val   <= '0;
         st_pend    <= 1'b0;
         st_val     <= '0;
         null_cnt   <= 1'b0;
         reload     <= '0;
         load       <= 1'b0;
      end else begin
         load <= load_now;
         if (load_now) begin
            reload   <= load_val;
            null_cnt <= 1'b1;
         end else if (loaded) begin
            null_cnt <= 1'b0;
         end

         if (data_wr && (acc == ACC_WORD)) begin
            wr_hi <= ~wr_hi;
            if (!wr_hi) hold <= wdata;
         end

         if (rd_hit) begin
            if (st_pend)
               st_pend <= 1'b0;
            else if (snap_state == ACC_WORD)
               snap_state <= ACC_HI;
            else if (snap_state != 2'd0)
               snap_state <= 2'd0;
            else if (acc == ACC_WORD)
               rd_hi <= ~rd_hi;
         end

         if (cnt_grab && (snap_state == 2'd0)) begin
            snap_val   <= live;
            snap_state <= acc;
         end
         if (st_grab && !st_pend) begin
            st_pend <= 1'b1;
            st_val  <= {out_lvl, null_cnt, acc, mode, bcd};
         end

         if (cfg_wr) begin
            acc   <= new_acc;
            mode  <= new_mode;
            bcd   <= new_bcd;
            wr_hi <= 1'b0;
            rd_hi <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/tmr_ctrl_if.sv
module tmr_ctrl_if
   import tmr_ctrl_pkg::*;
#(
   parameter int NUM_CH     = 3,
   parameter int DATA_W     = 8,
   parameter bit MODE_ALIAS = 1'b1,
   localparam int CNT_W     = 2 * DATA_W
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr_en,
   input  logic                    rd_en,
   input  logic [1:0]              addr,
   input  logic [DATA_W-1:0]       wdata,
   output logic [DATA_W-1:0]       rdata,
   input  logic [NUM_CH*CNT_W-1:0] live_count,
   input  logic [NUM_CH-1:0]       chan_out,
   input  logic [NUM_CH-1:0]       chan_loaded,
   output logic [NUM_CH*3-1:0]     chan_mode,
   output logic [NUM_CH-1:0]       chan_bcd,
   output logic [NUM_CH*CNT_W-1:0] chan_reload,
   output logic [NUM_CH-1:0]       chan_load
);

   generate
      if (NUM_CH < 1 || NUM_CH > 3) begin : g_bad_ch
         $error("tmr_ctrl_if: NUM_CH must be 1 to 3");
      end
      if (DATA_W != 8) begin : g_bad_w
         $error("tmr_ctrl_if: DATA_W must be 8");
      end
   endgenerate

   logic [NUM_CH-1:0] cfg_wr, data_wr, cnt_grab, st_grab;
   logic [1:0]        new_acc;
   logic [2:0]        new_mode;
   logic              new_bcd;
   logic [DATA_W-1:0] rbyte [NUM_CH];
   logic [DATA_W-1:0] sel_byte;

   tmr_cmd_decode #(
      .NUM_CH(NUM_CH), .DATA_W(DATA_W), .MODE_ALIAS(MODE_ALIAS)
   ) u_dec (
      .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .cfg_wr(cfg_wr), .data_wr(data_wr), .cnt_grab(cnt_grab), .st_grab(st_grab),
      .new_acc(new_acc), .new_mode(new_mode), .new_bcd(new_bcd)
   );

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         tmr_chan_regs #(.DATA_W(DATA_W)) u_regs (
            .clk(clk), .rst_n(rst_n),
            .cfg_wr(cfg_wr[i]), .new_acc(new_acc), .new_mode(new_mode), .new_bcd(new_bcd),
            .data_wr(data_wr[i]), .wdata(wdata),
            .cnt_grab(cnt_grab[i]), .st_grab(st_grab[i]),
            .rd_hit(rd_en && (addr == 2'(i))),
            .live(live_count[i*CNT_W +: CNT_W]),
            .out_lvl(chan_out[i]), .loaded(chan_loaded[i]),
            .mode(chan_mode[i*3 +: 3]), .bcd(chan_bcd[i]),
            .reload(chan_reload[i*CNT_W +: CNT_W]), .load(chan_load[i]),
            .rbyte(rbyte[i])
         );
      end
   endgenerate

   always_comb begin
      sel_byte = '0;
      for (int i = 0; i < NUM_CH; i++)
         if (addr == 2'(i)) sel_byte = rbyte[i];
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         rdata <= '0;
      else if (rd_en)
         rdata <= sel_byte;
   end

endmodule

// File: rtl/tmr_ctrl_if_chk.sv
module tmr_ctrl_if_chk #(
   parameter int NUM_CH     = 3,
   parameter int DATA_W     = 8,
   parameter bit MODE_ALIAS = 1'b1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                wr_en,
   input logic                rd_en,
   input logic [1:0]          addr,
   input logic [DATA_W-1:0]   rdata,
   input logic [NUM_CH*3-1:0] chan_mode,
   input logic [NUM_CH-1:0]   chan_load
);

   p_single_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(chan_load));

   p_load_needs_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_load != '0) |-> ($past(wr_en) && ($past(addr) != 2'd3)));

   p_no_write_no_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> (chan_load == '0));

   p_rdata_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));

   generate
      if (MODE_ALIAS) begin : g_fold
         for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
            p_mode_fold_r2: assert property (@(posedge clk) disable iff (!rst_n)
               chan_mode[i*3 +: 3] <= 3'd5);
         end
      end
   endgenerate

endmodule

bind tmr_ctrl_if tmr_ctrl_if_chk #(
   .NUM_CH(NUM_CH), .DATA_W(DATA_W), .MODE_ALIAS(MODE_ALIAS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
   .rdata(rdata), .chan_mode(chan_mode), .chan_load(chan_load)
);

// File: tb/tmr_ctrl_if_test.sv
module tmr_ctrl_if_test;

   localparam int NCH = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [1:0]    addr = '0;
   logic [7:0]    wdata = '0;
   logic [7:0]    rdata;
   logic [47:0]   live_count = '0;
   logic [2:0]    chan_out = '0;
   logic [2:0]    chan_loaded = '0;
   logic [8:0]    chan_mode;
   logic [2:0]    chan_bcd;
   logic [47:0]   chan_reload;
   logic [2:0]    chan_load;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   tmr_ctrl_if #(.NUM_CH(NCH)) uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .live_count(live_count), .chan_out(chan_out),
      .chan_loaded(chan_loaded), .chan_mode(chan_mode), .chan_bcd(chan_bcd),
      .chan_reload(chan_reload), .chan_load(chan_load)
   );

   always #2 clk = ~clk;

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      d = rdata;
   endtask

   function automatic logic [15:0] reload_of(input int ch);
      return chan_reload[ch*16 +: 16];
   endfunction

   task automatic t_reset();
      logic [7:0] b;
      chk("R1 rdata", 16'(rdata), 16'h0);
      chk("R1 load", 16'(chan_load), 16'h0);
      chk("R1 mode", 16'(chan_mode), 16'h0);
      chk("R1 reload", chan_reload[15:0] | chan_reload[31:16] | chan_reload[47:32], 16'h0);
      wr(2'd3, 8'hE4);
      rd(2'd1, b);
      chk("R1 status", 16'(b), 16'h0030);
   endtask

   task automatic t_ctrl_and_lsb();
      wr(2'd3, 8'h5F);
      chk("R2 mode fold", 16'(chan_mode[5:3]), 16'h3);
      chk("R2 bcd", 16'(chan_bcd[1]), 16'h1);
      wr(2'd1, 8'hA5);
      chk("R3 strobe", 16'(chan_load), 16'h2);
      chk("R3 value", reload_of(1), 16'h00A5);
      @(negedge clk);
      chk("R3 one cycle", 16'(chan_load), 16'h0);
   endtask

   task automatic t_msb();
      wr(2'd3, 8'hA4);
      chk("R2 mode 2", 16'(chan_mode[8:6]), 16'h2);
      wr(2'd2, 8'h3C);
      chk("R4 value", reload_of(2), 16'h3C00);
      chk("R4 strobe", 16'(chan_load), 16'h4);
   endtask

   task automatic t_word();
      wr(2'd3, 8'h36);
      wr(2'd0, 8'h34);
      chk("R5 first byte no load", 16'(chan_load), 16'h0);
      wr(2'd0, 8'h12);
      chk("R5 strobe", 16'(chan_load), 16'h1);
      chk("R5 value", reload_of(0), 16'h1234);
      wr(2'd0, 8'h77);
      chk("R6 half write no load", 16'(chan_load), 16'h0);
      wr(2'd3, 8'h36);
      wr(2'd0, 8'h78);
      chk("R6 pointer reset no load", 16'(chan_load), 16'h0);
      wr(2'd0, 8'h56);
      chk("R6 value", reload_of(0), 16'h5678);
   endtask

   task automatic t_live();
      logic [7:0] b;
      live_count[15:0]  = 16'hBEEF;
      live_count[31:16] = 16'h1357;
      rd(2'd0, b); chk("R12 live lo", 16'(b), 16'h00EF);
      rd(2'd0, b); chk("R12 live hi", 16'(b), 16'h00BE);
      rd(2'd1, b); chk("R12 lo only", 16'(b), 16'h0057);
      rd(2'd1, b); chk("R12 lo only again", 16'(b), 16'h0057);
      rd(2'd3, b); chk("R12 ctrl read", 16'(b), 16'h0000);
      repeat (3) @(negedge clk);
      chk("R13 hold", 16'(rdata), 16'h0000);
   endtask

   task automatic t_capture();
      logic [7:0] b;
      live_count[15:0] = 16'h1199;
      wr(2'd3, 8'h00);
      live_count[15:0] = 16'h2277;
      wr(2'd3, 8'h00);
      rd(2'd0, b); chk("R7 snap lo", 16'(b), 16'h0099);
      rd(2'd0, b); chk("R8 snap hi kept", 16'(b), 16'h0011);
      rd(2'd0, b); chk("R7 released lo", 16'(b), 16'h0077);
      rd(2'd0, b); chk("R7 released hi", 16'(b), 16'h0022);
      repeat (2) @(negedge clk);
      chk("R13 hold after read", 16'(rdata), 16'h0022);
   endtask

   task automatic t_readback();
      logic [7:0] b;
      chan_out = 3'b101;
      live_count[15:0]  = 16'h4321;
      live_count[47:32] = 16'h0A0B;
      wr(2'd3, 8'hCA);
      live_count[15:0]  = 16'h9999;
      live_count[47:32] = 16'h5500;
      wr(2'd3, 8'hCA);
      rd(2'd0, b); chk("R10 status ch0", 16'(b), 16'h00F6);
      rd(2'd0, b); chk("R9 ch0 lo", 16'(b), 16'h0021);
      rd(2'd0, b); chk("R9 ch0 hi", 16'(b), 16'h0043);
      rd(2'd2, b); chk("R10 status ch2", 16'(b), 16'h00E4);
      rd(2'd2, b); chk("R9 ch2 hi only", 16'(b), 16'h000A);
      rd(2'd2, b); chk("R9 ch2 released", 16'(b), 16'h0055);
      rd(2'd1, b); chk("R9 ch1 unselected", 16'(b), 16'h0057);
   endtask

   task automatic t_null();
      logic [7:0] b;
      @(negedge clk);
      chan_loaded = 3'b001;
      @(negedge clk);
      chan_loaded = 3'b000;
      wr(2'd3, 8'hE2);
      rd(2'd0, b); chk("R11 null cleared", 16'(b), 16'h00B6);
      rd(2'd0, b); chk("R11 status only", 16'(b), 16'h0099);
      wr(2'd3, 8'hE8);
      rd(2'd2, b); chk("R11 null kept ch2", 16'(b), 16'h00E4);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ctrl_and_lsb();
      t_msb();
      t_word();
      t_live();
      t_capture();
      t_readback();
      t_null();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual hung expected done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule